// File: doc/BRIEF.md
# Dual-Plane Page Write Controller

This block manages writes to a small nonvolatile-style byte store that is divided into two planes. The top address bit picks the plane. A host writes a page as a burst of single-byte writes that all fall in one aligned page. The bytes are held in a page buffer. Every accepted byte restarts a byte-load timer. When that timer runs out, an internal programming phase copies the buffered bytes into the store. This phase is modelled as a fixed number of clock cycles.

A host can check progress without a side channel. While a page is being loaded or programmed, reads that land in the busy plane return a status byte whose bit 6 flips on every such read. Reads that land in the other plane return real stored data, so code can keep running from that plane. A write-control input gives an external guard: it cancels a page that is still loading, and it blocks writes while it stays high.

Top module: `dp_page_writer`

## Requirements
- R1: A read (acc_en=1, acc_we=0) is answered on the clock edge after the edge that accepts it, with rd_valid high for exactly that one cycle. With no page active, rd_data carries the stored byte.
- R2: A write made while idle with wctl low opens a page. Its tag is acc_addr[ADDR_W-1:5] and its byte offset is acc_addr[4:0]. Up to PAGE_BYTES=32 bytes of that page are buffered. A later write to the same offset replaces the earlier one, and every buffered byte reaches the store.
- R3: While a page is open, a write whose address bits ADDR_W-1 down to 5 differ from the open tag is ignored. Neither location changes.
- R4: Each accepted byte restarts a LOAD_CYC-cycle window. If no byte is accepted within that window, programming begins. If a byte arrives in the same cycle that the window would close, the window restarts and the byte is kept.
- R5: Programming lasts PROG_CYC cycles. After that the block is idle and opens a new page on the next write.
- R6: While a page is loading or programming, a read from the plane that holds the page returns 8'h00 or 8'h40. The first such read after the page opens gives 8'h00, and each later one inverts bit 6. Once programming ends, reads return stored data again.
- R7: While a page is loading or programming, reads from the other plane return true stored data.
- R8: wctl high while a page is loading discards the page. Nothing is programmed and the block returns to idle. This also applies when wctl rises in the very cycle the load window closes.
- R9: While wctl is high, every write is ignored and reads work normally.
- R10: Any write arriving during programming, to either plane, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address; the top bit selects the plane |
| acc_wdata | input | 8 | Write data |
| wctl | input | 1 | Write-control guard; high aborts a loading page and blocks writes |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result: stored byte or polling status |

## Verification
Two events can fall on the same clock edge. One is the expiry of the byte-load window. The other is either a new same-page byte or a rise of wctl. The bench counts edges from the accepted write and places a second byte, and separately a one-cycle wctl pulse, exactly on the edge where the window closes. It then waits out a full programming time and reads the location back. For a restart, the late byte must be present in the store. For an abort, the old contents must be unchanged.

// File: rtl/dpw_pkg.sv
package dpw_pkg;

    localparam int DPW_DW      = 8;
    localparam int DPW_TOG_BIT = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } dpw_state_e;

    function automatic logic [DPW_DW-1:0] status_byte(input logic tog);
        logic [DPW_DW-1:0] v;
        v = '0;
        v[DPW_TOG_BIT] = tog;
        return v;
    endfunction

endpackage

// File: rtl/dpw_timer.sv
module dpw_timer #(
    parameter int CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic clr,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)          cnt_q <= '0;
        else if (load)           cnt_q <= CW'(CYC);
        else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    end

    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/dpw_page_buf.sv
module dpw_page_buf #(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        wr,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [dpw_pkg::DPW_DW-1:0]  wr_data,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [dpw_pkg::DPW_DW-1:0]  rd_data,
    output logic                        rd_vld
);
    logic [dpw_pkg::DPW_DW-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]           vld_q;

    always_ff @(posedge clk) begin
        if (rst || clr)  vld_q <= '0;
        else if (wr)     vld_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr) data_q[wr_idx] <= wr_data;
    end

    assign rd_data = data_q[rd_idx];
    assign rd_vld  = vld_q[rd_idx];
endmodule

// File: rtl/dpw_array.sv
module dpw_array #(
    parameter int ADDR_W = 11,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           waddr,
    input  logic [dpw_pkg::DPW_DW-1:0]  wdata,
    input  logic [ADDR_W-1:0]           raddr,
    output logic [dpw_pkg::DPW_DW-1:0]  rdata
);
    logic [dpw_pkg::DPW_DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/dp_page_writer.sv
module dp_page_writer #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 32,
    parameter int LOAD_CYC   = 20,
    parameter int PROG_CYC   = 200
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        acc_en,
    input  logic                        acc_we,
    input  logic [ADDR_W-1:0]           acc_addr,
    input  logic [dpw_pkg::DPW_DW-1:0]  acc_wdata,
    input  logic                        wctl,
    output logic                        rd_valid,
    output logic [dpw_pkg::DPW_DW-1:0]  rd_data
);
    import dpw_pkg::*;

    localparam int OFF_W     = $clog2(PAGE_BYTES);
    localparam int TAG_W     = ADDR_W - OFF_W;
    localparam int PLANE_BIT = ADDR_W - 1;

    dpw_state_e        state_q, state_d;
    logic [TAG_W-1:0]  tag_q;
    logic              tog_q;
    logic [OFF_W:0]    cidx_q;

    logic wr_req, rd_req, same_page, accept, abort;
    logic load_done, prog_done, enter_prog, poll_hit, commit_act;
    logic [DPW_DW-1:0] buf_rdata, arr_rdata, stat_q;
    logic              buf_rvld, poll_q;

    assign wr_req    = acc_en &  acc_we;
    assign rd_req    = acc_en & ~acc_we;
    assign same_page = (acc_addr[ADDR_W-1:OFF_W] == tag_q);
    assign accept    = wr_req & ~wctl &
                       ((state_q == ST_IDLE) | ((state_q == ST_LOAD) & same_page));
    assign abort     = (state_q == ST_LOAD) & wctl;
    assign enter_prog = (state_q == ST_LOAD) & load_done & ~accept & ~wctl;
    assign poll_hit  = rd_req & (state_q != ST_IDLE) &
                       (acc_addr[PLANE_BIT] == tag_q[TAG_W-1]);
    assign commit_act = (state_q == ST_PROG) & (cidx_q < (OFF_W+1)'(PAGE_BYTES));

    // Priority inside LOAD: abort, then byte restart, then expiry.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_LOAD;
            ST_LOAD: begin
                if (abort)           state_d = ST_IDLE;
                else if (enter_prog) state_d = ST_PROG;
            end
            ST_PROG: if (prog_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tag_q   <= '0;
            tog_q   <= 1'b0;
            cidx_q  <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && accept) begin
                tag_q <= acc_addr[ADDR_W-1:OFF_W];
                tog_q <= 1'b0;
            end else if (poll_hit) begin
                tog_q <= ~tog_q;
            end
            if (enter_prog)      cidx_q <= '0;
            else if (commit_act) cidx_q <= cidx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            poll_q   <= 1'b0;
            stat_q   <= '0;
        end else begin
            rd_valid <= rd_req;
            poll_q   <= poll_hit;
            stat_q   <= status_byte(tog_q);
        end
    end

    assign rd_data = poll_q ? stat_q : arr_rdata;

    dpw_timer #(.CYC(LOAD_CYC)) u_load_tmr (
        .clk(clk), .rst(rst), .load(accept), .clr(abort), .done(load_done)
    );

    dpw_timer #(.CYC(PROG_CYC)) u_prog_tmr (
        .clk(clk), .rst(rst), .load(enter_prog), .clr(1'b0), .done(prog_done)
    );

    dpw_page_buf #(.DEPTH(PAGE_BYTES), .IDX_W(OFF_W)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .clr     (abort | ((state_q == ST_PROG) & prog_done)),
        .wr      (accept),
        .wr_idx  (acc_addr[OFF_W-1:0]),
        .wr_data (acc_wdata),
        .rd_idx  (cidx_q[OFF_W-1:0]),
        .rd_data (buf_rdata),
        .rd_vld  (buf_rvld)
    );

    dpw_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk   (clk),
        .we    (commit_act & buf_rvld),
        .waddr ({tag_q, cidx_q[OFF_W-1:0]}),
        .wdata (buf_rdata),
        .raddr (acc_addr),
        .rdata (arr_rdata)
    );
endmodule

// File: rtl/dpw_checker.sv
module dpw_checker #(
    parameter int PROG_CYC = 200,
    parameter int TAG_W    = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               acc_en,
    input logic               acc_we,
    input logic               wctl,
    input logic               rd_valid,
    input dpw_pkg::dpw_state_e state,
    input logic [TAG_W-1:0]   tag
);
    import dpw_pkg::*;

    localparam int PW = $clog2(PROG_CYC + 1);
    logic [PW-1:0] prog_cnt;

    always_ff @(posedge clk) begin
        if (rst || state != ST_PROG) prog_cnt <= '0;
        else                         prog_cnt <= prog_cnt + 1'b1;
    end

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_we) |=> rd_valid);                                   // R1
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
        !(acc_en && !acc_we) |=> !rd_valid);                                 // R1
    AST_TAG_HELD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |=> (state != ST_LOAD || $stable(tag)));          // R3
    AST_PROG_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROG) |-> (prog_cnt < PW'(PROG_CYC)));                  // R5
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD && wctl) |=> (state == ST_IDLE));                  // R8
    AST_WCTL_NO_OPEN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && wctl) |=> (state == ST_IDLE));                  // R9
    AST_PROG_NO_REOPEN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROG) |=> (state != ST_LOAD));                          // R10
endmodule

bind dp_page_writer dpw_checker #(.PROG_CYC(PROG_CYC), .TAG_W(TAG_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .acc_en   (acc_en),
    .acc_we   (acc_we),
    .wctl     (wctl),
    .rd_valid (rd_valid),
    .state    (state_q),
    .tag      (tag_q)
);

// File: tb/dp_page_writer_test.sv
module dp_page_writer_test;
    localparam int AW = 11;
    localparam int L  = 20;
    localparam int P  = 200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_en = 1'b0, acc_we = 1'b0, wctl = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [7:0]    acc_wdata = '0;
    logic          rd_valid;
    logic [7:0]    rd_data;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    dp_page_writer #(.ADDR_W(AW), .PAGE_BYTES(32), .LOAD_CYC(L), .PROG_CYC(P)) uut (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .wctl(wctl),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // page at 0x040..0x05F: {address, data}
    localparam logic [18:0] PAGE_TBL [8] = '{
        {11'h040, 8'hA0}, {11'h05F, 8'h17}, {11'h047, 8'h3C}, {11'h04A, 8'hE5},
        {11'h055, 8'h09}, {11'h041, 8'h7E}, {11'h050, 8'hC2}, {11'h05E, 8'h66}
    };

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0;
        d = rd_data;
    endtask

    task automatic quiet();
        repeat (L + P + 8) @(posedge clk);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset rd_valid", {7'b0, rd_valid}, 8'h00);

        // R2: table-driven page load and readback
        for (int i = 0; i < 8; i++) wr(PAGE_TBL[i][18:8], PAGE_TBL[i][7:0]);
        quiet();
        for (int i = 0; i < 8; i++) begin
            rd(PAGE_TBL[i][18:8], v);
            chk("R2 page readback", v, PAGE_TBL[i][7:0]);
        end
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = 11'h040;
        @(posedge clk); @(negedge clk);
        acc_en = 1'b0;
        chk("R1 rd_valid one cycle", {7'b0, rd_valid}, 8'h01);
        @(negedge clk);
        chk("R1 rd_valid drops", {7'b0, rd_valid}, 8'h00);

        // R2: overwrite at same offset
        wr(11'h060, 8'h11);
        wr(11'h060, 8'h22);
        quiet();
        rd(11'h060, v); chk("R2 offset overwrite", v, 8'h22);

        // preload plane 1
        wr(11'h410, 8'h5A);
        quiet();

        // R6 / R7: polling on busy plane, true data on the other
        wr(11'h080, 8'h3C);
        rd(11'h081, v); chk("R6 first poll", v, 8'h00);
        rd(11'h410, v); chk("R7 other plane during load", v, 8'h5A);
        rd(11'h081, v); chk("R6 second poll", v, 8'h40);
        rd(11'h081, v); chk("R6 third poll", v, 8'h00);
        repeat (L + 2) @(posedge clk);
        rd(11'h081, v); chk("R6 poll during programming", v, 8'h40);
        rd(11'h410, v); chk("R7 other plane during programming", v, 8'h5A);
        // R10: writes during programming
        wr(11'h410, 8'h11);
        wr(11'h080, 8'h22);
        quiet();
        rd(11'h080, v); chk("R6 data after programming", v, 8'h3C);
        rd(11'h080, v); chk("R6 toggling stopped", v, 8'h3C);
        rd(11'h410, v); chk("R10 idle-plane write dropped", v, 8'h5A);

        // R3: different-page write while page open
        wr(11'h0C0, 8'h33);
        wr(11'h040, 8'h99);
        quiet();
        rd(11'h0C0, v); chk("R3 open page byte", v, 8'h33);
        rd(11'h040, v); chk("R3 foreign write ignored", v, 8'hA0);

        // R4: restart keeps page open
        wr(11'h100, 8'h01);
        repeat (L - 3) @(posedge clk);
        wr(11'h101, 8'h02);
        repeat (L - 3) @(posedge clk);
        wr(11'h102, 8'h03);
        quiet();
        rd(11'h100, v); chk("R4 restart byte0", v, 8'h01);
        rd(11'h102, v); chk("R4 restart byte2", v, 8'h03);

        // R4: byte arriving on the expiry edge restarts the window
        wr(11'h140, 8'h61);
        repeat (L - 1) @(posedge clk);
        wr(11'h141, 8'h62);
        quiet();
        rd(11'h141, v); chk("R4 byte on expiry edge kept", v, 8'h62);
        rd(11'h140, v); chk("R4 first byte kept", v, 8'h61);

        // R4 / R10: expiry starts programming, later write dropped
        wr(11'h160, 8'h70);
        repeat (L + 5) @(posedge clk);
        wr(11'h160, 8'h71);
        quiet();
        rd(11'h160, v); chk("R10 write in programming dropped", v, 8'h70);

        // R8: abort
        wr(11'h180, 8'hA1);
        quiet();
        wr(11'h180, 8'hB2);
        repeat (3) @(posedge clk);
        @(negedge clk); wctl = 1'b1;
        @(posedge clk); @(negedge clk); wctl = 1'b0;
        quiet();
        rd(11'h180, v); chk("R8 abort discards page", v, 8'hA1);
        wr(11'h180, 8'hC3);
        repeat (L - 1) @(posedge clk);
        @(negedge clk); wctl = 1'b1;
        @(posedge clk); @(negedge clk); wctl = 1'b0;
        quiet();
        rd(11'h180, v); chk("R8 abort on expiry edge", v, 8'hA1);

        // R9: writes blocked while wctl high, reads still work
        @(negedge clk); wctl = 1'b1;
        wr(11'h180, 8'hD4);
        rd(11'h180, v); chk("R9 read with wctl high", v, 8'hA1);
        @(negedge clk); wctl = 1'b0;
        quiet();
        rd(11'h180, v); chk("R9 write ignored", v, 8'hA1);

        summary();
        $finish;
    end
endmodule